// File: doc/BRIEF.md
# Port Interrupt Status and Enable Unit

This unit gathers twelve single-cycle event pulses from one port and turns them into sticky status bits. Each bit is shown twice in one 32-bit status word: the bare condition in the upper half and the same condition gated by its enable in the lower half. Software clears a source by writing 1 to it in either half. A new event that lands in the same cycle as any clear takes priority.

The enable mask is reached through two addresses. One sets the bits written as 1. The other clears the bits written as 1. Both return the current mask. The top two bits of the mask word form a steering field that selects which of four interrupt lines carries the port interrupt. The status word never shows that field. A control input selects whether a read of the slot status register (signalled by a pulse input) clears the command-complete source automatically, or whether software must clear it with a write.

Top module: `irq_stat_top`

## Requirements
- R1: After reset the status bits, enable bits and steering field are all zero, every bit of irqLine is 0, and rdData is zero.
- R2: An evtPulse on source i (bits 0 to 11; bit 0 is command complete) sets the status word's raw bit 16+i on the next clock, and bit i of the status word reads raw AND enable for source i.
- R3: A write to the status address 0x00 with bit i or bit 16+i at 1 clears source i. Bits written as 0 leave their sources unchanged.
- R4: If an event pulse for a source arrives in the same cycle as any clear of that source (a status write or an auto-clear), the source stays set.
- R5: A write to 0x04 sets enable bits 11:0 and steering bits 31:30 wherever the data is 1. A write to 0x08 clears them wherever the data is 1. A read of either address returns {steer[1:0], 18'b0, enable[11:0]}.
- R6: Status-word bits 31:28 and 15:12 always read zero, whatever the steering field holds.
- R7: When any masked status bit is set, irqLine equals 1 << steer. Otherwise irqLine is zero. It follows register state with no extra delay.
- R8: With noAutoClr = 0, a slotStatRd pulse clears source 0. With noAutoClr = 1 the pulse has no effect, and source 0 clears only through R3.
- R9: rdData takes the value addressed on an rdEn cycle at the next clock edge and holds it until the next read. Reads of addresses other than 0x00, 0x04 and 0x08 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | 12 | One-cycle event pulses, one per source |
| slotStatRd | input | 1 | Pulse: the slot status register was read |
| noAutoClr | input | 1 | 1 disables the auto-clear of command complete |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| irqLine | output | 4 | Steered interrupt lines, at most one high |

## Verification
A wrong internal bit appears in two ways: in the next status read, and in irqLine within the same cycle the register updates. A stuck or mis-cleared source therefore shows on irqLine one cycle after the offending pulse or write, provided its enable is set. Enable or steering errors appear on the very next read of 0x04 or 0x08, and as a wrong irqLine one-hot. Priority bugs between an event and a clear show only on the cycle where both coincide, so the stimulus forces that overlap for both the write path and the auto-clear path.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int ADDR_STS   = 'h00;
  localparam int ADDR_ENSET = 'h04;
  localparam int ADDR_ENCLR = 'h08;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic stsClr;   // write to status word
    logic enSet;    // W1S of enable
    logic enClr;    // W1C of enable
    logic autoClr;  // clear command-complete on slot status read
    logic rdLoad;   // capture read data this cycle
    logic rdSts;    // read selects status word
    logic rdEnb;    // read selects enable word
  } strobe_t;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              slotStatRd,
  input  logic              noAutoClr,
  output strobe_t           strobe
);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(ADDR_STS);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ADDR_ENSET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ADDR_ENCLR);

  logic hitSts, hitSet, hitClr;

  always_comb begin
    hitSts = (addr == A_STS);
    hitSet = (addr == A_SET);
    hitClr = (addr == A_CLR);
    strobe.stsClr  = wrEn && hitSts;
    strobe.enSet   = wrEn && hitSet;
    strobe.enClr   = wrEn && hitClr;
    strobe.autoClr = slotStatRd && !noAutoClr;
    strobe.rdLoad  = rdEn;
    strobe.rdSts   = rdEn && hitSts;
    strobe.rdEnb   = rdEn && (hitSet || hitClr);
  end
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int DATA_W  = 32,
  parameter int STEER_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic [NUM_SRC-1:0]     evtPulse,
  input  logic [DATA_W-1:0]      wrData,
  output logic [DATA_W-1:0]      rdData,
  output logic [(1<<STEER_W)-1:0] irqLine,
  output logic [NUM_SRC-1:0]     stsRaw,
  output logic [NUM_SRC-1:0]     enMask
);
  localparam int RAW_LSB = DATA_W / 2;
  localparam int LINES   = 1 << STEER_W;

  logic [NUM_SRC-1:0] stsReg, enReg, clrMask;
  logic [STEER_W-1:0] steerReg;
  logic [DATA_W-1:0]  stsWord, enWord, rdNext;
  logic               anyIrq;
  logic               unusedBits;

  assign unusedBits = ^wrData;

  always_comb begin
    clrMask = '0;
    if (strobe.stsClr)
      clrMask = wrData[NUM_SRC-1:0] | wrData[RAW_LSB +: NUM_SRC];
    if (strobe.autoClr)
      clrMask[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stsReg   <= '0;
      enReg    <= '0;
      steerReg <= '0;
    end else begin
      stsReg <= (stsReg & ~clrMask) | evtPulse;  // event wins
      if (strobe.enSet) begin
        enReg    <= enReg | wrData[NUM_SRC-1:0];
        steerReg <= steerReg | wrData[DATA_W-1 -: STEER_W];
      end else if (strobe.enClr) begin
        enReg    <= enReg & ~wrData[NUM_SRC-1:0];
        steerReg <= steerReg & ~wrData[DATA_W-1 -: STEER_W];
      end
    end
  end

  always_comb begin
    stsWord = '0;
    stsWord[NUM_SRC-1:0]       = stsReg & enReg;
    stsWord[RAW_LSB +: NUM_SRC] = stsReg;
    enWord = '0;
    enWord[NUM_SRC-1:0]          = enReg;
    enWord[DATA_W-1 -: STEER_W]  = steerReg;
    rdNext = '0;
    if (strobe.rdSts) rdNext = stsWord;
    else if (strobe.rdEnb) rdNext = enWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobe.rdLoad) rdData <= rdNext;
  end

  assign anyIrq = |(stsReg & enReg);

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign irqLine[k] = anyIrq && (steerReg == STEER_W'(k));
  end

  assign stsRaw = stsReg;
  assign enMask = enReg;
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int STEER_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_SRC-1:0]      evtPulse,
  input  logic                    slotStatRd,
  input  logic                    noAutoClr,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic [(1<<STEER_W)-1:0] irqLine
);
  strobe_t            strobe;
  logic [NUM_SRC-1:0] stsRaw, enMask;

  irq_stat_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .slotStatRd(slotStatRd), .noAutoClr(noAutoClr), .strobe(strobe)
  );

  irq_stat_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .STEER_W(STEER_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtPulse(evtPulse),
    .wrData(wrData), .rdData(rdData), .irqLine(irqLine),
    .stsRaw(stsRaw), .enMask(enMask)
  );
endmodule

// File: rtl/irq_stat_chk.sv
module irq_stat_chk #(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int LINES   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [LINES-1:0]   irqLine,
  input logic [NUM_SRC-1:0] stsRaw,
  input logic [NUM_SRC-1:0] enMask
);
  logic unmapped;
  assign unmapped = (addr != ADDR_W'(0)) && (addr != ADDR_W'(4)) && (addr != ADDR_W'(8));

  // R4: a pulsed source is set on the next cycle whatever else happened
  p_event_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((stsRaw & $past(evtPulse)) == $past(evtPulse)));

  // R2: no status bit rises without an event
  p_no_spurious_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((stsRaw & ~$past(stsRaw) & ~$past(evtPulse)) == '0));

  // R7: at most one line, and active exactly when a masked bit is set
  p_one_line_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLine));
  p_line_tracks_mask_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|irqLine) == (|(stsRaw & enMask)));

  // R5: clearing enable bits leaves them clear
  p_enable_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(8)) |=> ((enMask & $past(wrData[NUM_SRC-1:0])) == '0));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && unmapped) |=> (rdData == '0));
endmodule

bind irq_stat_top irq_stat_chk #(
  .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(1 << STEER_W)
) uChk (
  .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .wrData(wrData), .rdData(rdData), .irqLine(irqLine),
  .stsRaw(stsRaw), .enMask(enMask)
);

// File: tb/irq_stat_top_test.sv
module irq_stat_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] evtPulse = '0;
  logic        slotStatRd = 1'b0;
  logic        noAutoClr = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  irqLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  irq_stat_top uut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .slotStatRd(slotStatRd),
    .noAutoClr(noAutoClr), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqLine(irqLine)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle and returns at the next negedge
  task automatic step(bit w, bit r, logic [7:0] a, logic [31:0] d,
                      logic [11:0] e, bit srd);
    wrEn = w; rdEn = r; addr = a; wrData = d; evtPulse = e; slotStatRd = srd;
    @(posedge clk);
    @(negedge clk);
    wrEn = 0; rdEn = 0; addr = '0; wrData = '0; evtPulse = '0; slotStatRd = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    step(1, 0, a, d, '0, 0);
  endtask

  task automatic pulse(logic [11:0] e);
    step(0, 0, '0, '0, e, 0);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    step(0, 1, a, '0, '0, 0);
  endtask

  // Monitor: a read seen at a rising edge is compared at the following falling edge
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn) begin
        @(negedge clk);
        if (expQ.size() == 0) begin
          checkEq("R9 unexpected read", rdData, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checkEq(t, rdData, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1 rdData at reset", rdData, 32'h0);
    checkEq("R1 irqLine at reset", {28'h0, irqLine}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    rd(8'h00, 32'h0, "R1 status after reset");
    rd(8'h04, 32'h0, "R1 enable after reset");

    // R2: raw set, masked view zero without enable
    pulse(12'h005);
    rd(8'h00, 32'h0005_0000, "R2 raw only");
    checkEq("R7 no enable no irq", {28'h0, irqLine}, 32'h0);

    // R5 / R2 / R7
    wr(8'h04, 32'h0000_0004);
    rd(8'h04, 32'h0000_0004, "R5 read via set address");
    rd(8'h08, 32'h0000_0004, "R5 read via clear address");
    rd(8'h00, 32'h0005_0004, "R2 masked view");
    checkEq("R7 steer 0", {28'h0, irqLine}, 32'h1);

    // R5 steering, R6 invisible in status, R7 line select
    wr(8'h04, 32'h8000_0000);
    rd(8'h04, 32'h8000_0004, "R5 steering readback");
    checkEq("R7 steer 2", {28'h0, irqLine}, 32'h4);
    rd(8'h00, 32'h0005_0004, "R6 steer hidden");

    // R3: clear via masked half, then raw half
    wr(8'h00, 32'h0000_0004);
    checkEq("R7 irq drops after clear", {28'h0, irqLine}, 32'h0);
    rd(8'h00, 32'h0001_0000, "R3 masked-half clear");
    wr(8'h00, 32'h0001_0000);
    rd(8'h00, 32'h0000_0000, "R3 raw-half clear");

    // R4: event and clear in one cycle
    step(1, 0, 8'h00, 32'h0800_0800, 12'h800, 0);
    rd(8'h00, 32'h0800_0000, "R4 event beats write clear");

    // R5 W1C on steering, W1S on enable
    wr(8'h08, 32'h8000_0000);
    wr(8'h04, 32'h0000_0800);
    rd(8'h08, 32'h0000_0804, "R5 after clear and set");
    checkEq("R7 back to line 0", {28'h0, irqLine}, 32'h1);

    // R3: zeros do nothing
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0800_0800, "R3 zero write no effect");

    wr(8'h08, 32'h0000_0800);
    rd(8'h04, 32'h0000_0004, "R5 enable bit cleared");
    checkEq("R7 masked off", {28'h0, irqLine}, 32'h0);

    // R8: auto-clear enabled
    noAutoClr = 1'b0;
    pulse(12'h001);
    rd(8'h00, 32'h0801_0000, "R2 command complete set");
    step(0, 0, '0, '0, '0, 1);
    rd(8'h00, 32'h0800_0000, "R8 auto-clear on slot read");

    // R8: auto-clear disabled
    noAutoClr = 1'b1;
    pulse(12'h001);
    step(0, 0, '0, '0, '0, 1);
    rd(8'h00, 32'h0801_0000, "R8 slot read ignored");
    wr(8'h00, 32'h0000_0001);
    rd(8'h00, 32'h0800_0000, "R8 software clear");

    // R4: event beats auto-clear
    noAutoClr = 1'b0;
    step(0, 0, '0, '0, 12'h001, 1);
    rd(8'h00, 32'h0801_0000, "R4 event beats auto-clear");

    // R6 / R7: steering 3, all status pad bits zero
    wr(8'h04, 32'hC000_0000);
    pulse(12'h004);
    checkEq("R7 steer 3", {28'h0, irqLine}, 32'h8);
    rd(8'h00, 32'h0805_0004, "R6 pad bits zero");

    // R9: unmapped reads and hold
    rd(8'h0C, 32'h0, "R9 unmapped 0x0C");
    rd(8'h04, 32'hC000_0004, "R9 mapped read");
    @(negedge clk);
    checkEq("R9 rdData holds", rdData, 32'hC000_0004);
    rd(8'h40, 32'h0, "R9 unmapped 0x40");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule